// File: doc/BRIEF.md
# Packet Stream Transmit Source Adapter

This block sits between a user-side producer of packet beats and a 128-bit packet streaming port of a transmit core. The user pushes beats (data, start and end markers, an upper-half-empty flag, a per-packet nullable flag and an optional nullify request) into an internal buffer with a plain valid/ready handshake. The adapter forwards a packet to the core only once every beat of it is held locally, so a packet, once started, never stalls for lack of data.

On the core side the ready input is honoured with a fixed latency of two cycles: a beat may be presented only in a cycle where ready was high two cycles earlier, and every presented beat counts as transferred. Ready and valid are both registered inside the block. A nullify request on a middle beat of a nullable packet turns into a single-cycle error pulse on that beat; a request that cannot be honoured is dropped and reported on a status pulse. A nullified packet is followed by one forced idle cycle before the next packet may start.

Top module: `ptx_tx_adapter`

## Requirements
- R1: `tx_valid_o` is high in a cycle only if `tx_ready_i` was high two cycles earlier; so after ready falls, valid is low again within two cycles.
- R2: While a packet is part-sent (start beat delivered, end beat not yet), `tx_valid_o` is high in every cycle for which `tx_ready_i` was high two cycles earlier.
- R3: Every accepted input beat appears on the output exactly once, in input order, with its data and start/end markers unchanged; a packet starts on the output only when all of its beats are buffered. Packets may be at most DEPTH beats long.
- R4: `tx_empty_o` is high only together with `tx_valid_o` and `tx_eop_o`, and then equals the `in_upper_empty_i` value given with that end beat (1 = bits 127:64 hold no data); it is 0 on all other beats.
- R5: A nullify request on an accepted beat that is neither a start nor an end beat, in a packet whose start beat had `in_nullable_i`=1, is carried out: `tx_err_o` is high for exactly that one beat, with `tx_valid_o` high. At most one such pulse occurs per packet.
- R6: A nullify request on a start beat, an end beat, a beat of a non-nullable packet, or after the packet was already nullified is ignored: no `tx_err_o` pulse results, and `null_rej_o` is high for one cycle in the cycle after that beat is accepted.
- R7: After the end beat of a nullified packet, the next cycle carries no start beat.
- R8: After reset `tx_valid_o`, `tx_err_o` and `null_rej_o` are 0 and `in_ready_o` is 1; `in_ready_o` is 0 exactly while DEPTH beats are buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | User beat valid |
| in_ready_o | output | 1 | Buffer can take a beat |
| in_data_i | input | 128 | User beat data |
| in_sop_i | input | 1 | First beat of a packet |
| in_eop_i | input | 1 | Last beat of a packet |
| in_upper_empty_i | input | 1 | Upper 64 bits of the last beat unused |
| in_nullable_i | input | 1 | Packet may be nullified (sampled on start beat) |
| in_nullify_i | input | 1 | Request to nullify the packet on this beat |
| null_rej_o | output | 1 | One-cycle pulse: nullify request ignored |
| tx_valid_o | output | 1 | Beat presented to the core |
| tx_ready_i | input | 1 | Core ready, two-cycle latency |
| tx_data_o | output | 128 | Beat data |
| tx_sop_o | output | 1 | Start of packet |
| tx_eop_o | output | 1 | End of packet |
| tx_empty_o | output | 1 | Upper half of end beat empty |
| tx_err_o | output | 1 | Nullify pulse |

## Verification
The bound checker watches on every cycle the two-cycle ready rule, the absence of bubbles inside a part-sent packet, the placement of error and empty on the correct beat kinds, the single error pulse per packet, the idle cycle after a nullified packet and the cause behind each rejection pulse. Only the bench scenarios can show that beats arrive once and in order with the right data, that the right requests are accepted or rejected by packet type and position, and that the input side stalls exactly when the buffer is full, under steady, random and toggling ready patterns.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  typedef struct packed {
    logic sop;
    logic eop;
    logic upper_empty;
    logic err;
  } beat_meta_t;
endpackage

// File: rtl/ptx_null_filter.sv
module ptx_null_filter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  input  logic sop_i,
  input  logic eop_i,
  input  logic nullable_i,
  input  logic nullify_i,
  output logic err_o,
  output logic rej_o
);
  logic nullable_q, done_q, nullable_cur, middle;

  // start beat supplies its own nullable flag
  assign nullable_cur = sop_i ? nullable_i : nullable_q;
  assign middle       = !sop_i && !eop_i;
  assign err_o        = nullify_i && middle && nullable_cur && !done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nullable_q <= 1'b0;
      done_q     <= 1'b0;
      rej_o      <= 1'b0;
    end else begin
      rej_o <= acc_i && nullify_i && !err_o;
      if (acc_i) begin
        if (sop_i) begin
          nullable_q <= nullable_i;
          done_q     <= 1'b0;
        end
        if (err_o) done_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ptx_fifo.sv
module ptx_fifo #(
  parameter int DW    = 128,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    push_i,
  input  logic [DW-1:0]           wdata_i,
  input  ptx_pkg::beat_meta_t     wmeta_i,
  input  logic                    pop_i,
  output logic [DW-1:0]           rdata_o,
  output ptx_pkg::beat_meta_t     rmeta_o,
  output logic                    full_o
);
  localparam int EW = DW + $bits(ptx_pkg::beat_meta_t);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  assign full_o           = (cnt == CW'(DEPTH));
  assign {rdata_o, rmeta_o} = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= {wdata_i, wmeta_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_i)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      cnt <= cnt + CW'(push_i) - CW'(pop_i);
    end
  end
endmodule

// File: rtl/ptx_sched.sv
module ptx_sched #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tx_ready_i,
  input  logic                push_eop_i,
  input  ptx_pkg::beat_meta_t head_i,
  output logic                pop_o
);
  logic          rdy_q, in_pkt_q, nerr_q, gap_q;
  logic [CW-1:0] pkt_cnt;
  logic          pop_eop;

  // start only with a whole packet buffered, so no underrun mid-packet
  assign pop_o   = rdy_q && (in_pkt_q || (pkt_cnt != '0 && !gap_q));
  assign pop_eop = pop_o && head_i.eop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q    <= 1'b0;
      in_pkt_q <= 1'b0;
      nerr_q   <= 1'b0;
      gap_q    <= 1'b0;
      pkt_cnt  <= '0;
    end else begin
      rdy_q   <= tx_ready_i;
      gap_q   <= pop_eop && nerr_q;
      pkt_cnt <= pkt_cnt + CW'(push_eop_i) - CW'(pop_eop);
      if (pop_o) begin
        in_pkt_q <= !head_i.eop;
        if (head_i.eop)      nerr_q <= 1'b0;
        else if (head_i.err) nerr_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ptx_tx_adapter.sv
module ptx_tx_adapter #(
  parameter int DW    = 128,
  parameter int DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_sop_i,
  input  logic          in_eop_i,
  input  logic          in_upper_empty_i,
  input  logic          in_nullable_i,
  input  logic          in_nullify_i,
  output logic          null_rej_o,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_sop_o,
  output logic          tx_eop_o,
  output logic          tx_empty_o,
  output logic          tx_err_o
);
  import ptx_pkg::*;

  logic       acc, full, pop, err_ok;
  beat_meta_t wmeta, head;
  logic [DW-1:0] head_data;

  assign in_ready_o = !full;
  assign acc        = in_valid_i && in_ready_o;

  ptx_null_filter u_filt (
    .clk_i, .rst_ni,
    .acc_i      (acc),
    .sop_i      (in_sop_i),
    .eop_i      (in_eop_i),
    .nullable_i (in_nullable_i),
    .nullify_i  (in_nullify_i),
    .err_o      (err_ok),
    .rej_o      (null_rej_o)
  );

  always_comb begin
    wmeta.sop         = in_sop_i;
    wmeta.eop         = in_eop_i;
    wmeta.upper_empty = in_eop_i && in_upper_empty_i;
    wmeta.err         = err_ok;
  end

  ptx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i  (acc),
    .wdata_i (in_data_i),
    .wmeta_i (wmeta),
    .pop_i   (pop),
    .rdata_o (head_data),
    .rmeta_o (head),
    .full_o  (full)
  );

  ptx_sched #(.DEPTH(DEPTH)) u_sched (
    .clk_i, .rst_ni,
    .tx_ready_i,
    .push_eop_i (acc && in_eop_i),
    .head_i     (head),
    .pop_o      (pop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_sop_o   <= 1'b0;
      tx_eop_o   <= 1'b0;
      tx_empty_o <= 1'b0;
      tx_err_o   <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      tx_valid_o <= pop;
      tx_sop_o   <= pop && head.sop;
      tx_eop_o   <= pop && head.eop;
      tx_empty_o <= pop && head.upper_empty;
      tx_err_o   <= pop && head.err;
      if (pop) tx_data_o <= head_data;
    end
  end
endmodule

// File: rtl/ptx_tx_adapter_chk.sv
module ptx_tx_adapter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic in_valid_i,
  input logic in_ready_o,
  input logic in_nullify_i,
  input logic null_rej_o,
  input logic tx_valid_o,
  input logic tx_ready_i,
  input logic tx_sop_o,
  input logic tx_eop_o,
  input logic tx_empty_o,
  input logic tx_err_o
);
  logic open_q, nerr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      nerr_q <= 1'b0;
    end else if (tx_valid_o) begin
      open_q <= !tx_eop_o;
      nerr_q <= tx_eop_o ? 1'b0 : (nerr_q || tx_err_o);
    end
  end

  AST_VALID_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(tx_ready_i, 2)); // R1
  AST_NO_MID_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_q && $past(tx_ready_i, 2) |-> tx_valid_o); // R2
  AST_FRAMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (tx_sop_o != open_q)); // R3
  AST_EMPTY_ON_EOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> tx_valid_o && tx_eop_o); // R4
  AST_ERR_MIDDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_err_o |-> tx_valid_o && !tx_sop_o && !tx_eop_o); // R5
  AST_ERR_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_err_o |-> !nerr_q); // R5
  AST_REJ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    null_rej_o |-> $past(in_valid_i && in_ready_o && in_nullify_i)); // R6
  AST_GAP_AFTER_NULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_eop_o && nerr_q |=> !(tx_valid_o && tx_sop_o)); // R7
endmodule

bind ptx_tx_adapter ptx_tx_adapter_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_ready_o   (in_ready_o),
  .in_nullify_i (in_nullify_i),
  .null_rej_o   (null_rej_o),
  .tx_valid_o   (tx_valid_o),
  .tx_ready_i   (tx_ready_i),
  .tx_sop_o     (tx_sop_o),
  .tx_eop_o     (tx_eop_o),
  .tx_empty_o   (tx_empty_o),
  .tx_err_o     (tx_err_o)
);

// File: tb/ptx_tx_adapter_tb_top.sv
module ptx_tx_adapter_tb_top;
  localparam int DW = 128, DEPTH = 16, EW = DW + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          in_valid = 0, in_sop = 0, in_eop = 0, in_emp = 0, in_nable = 0, in_nreq = 0;
  logic [DW-1:0] in_data = '0;
  logic          tx_ready = 0;
  logic          in_ready, null_rej, tx_valid, tx_sop, tx_eop, tx_empty, tx_err;
  logic [DW-1:0] tx_data;

  ptx_tx_adapter #(.DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_sop_i(in_sop), .in_eop_i(in_eop), .in_upper_empty_i(in_emp),
    .in_nullable_i(in_nable), .in_nullify_i(in_nreq), .null_rej_o(null_rej),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .tx_sop_o(tx_sop), .tx_eop_o(tx_eop), .tx_empty_o(tx_empty), .tx_err_o(tx_err)
  );

  int checks = 0, fails = 0, cyc = 0, rdy_mode = 2;
  int rej_seen = 0, exp_rej = 0, err_seen = 0, exp_err = 0;
  int unsigned seq = 0;
  logic [EW-1:0] exp_q[$];
  logic [1:0] rh = '0;
  bit m_nable = 0, m_done = 0, open = 0, pkt_err = 0, gap_pend = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [EW-1:0] act, input logic [EW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    rh <= {rh[0], tx_ready};
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      summary();
    end
  end

  always @(negedge clk) begin
    case (rdy_mode)
      0: tx_ready <= 1'b1;
      1: tx_ready <= ($urandom % 3) != 0;
      3: tx_ready <= ~tx_ready;
      default: tx_ready <= 1'b0;
    endcase
  end

  // output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (null_rej) rej_seen++;
      if (gap_pend && tx_valid && tx_sop)
        chk(0, "R7", "start right after nullified packet", 1, 0);
      gap_pend = 0;
      if (open && rh[1] && !tx_valid)
        chk(0, "R2", "bubble inside packet", 0, 1);
      if (tx_valid) begin
        logic [EW-1:0] got, exp;
        got = {tx_data, tx_sop, tx_eop, tx_empty, tx_err};
        chk(rh[1], "R1", "valid without ready two cycles before", 0, 1);
        if (exp_q.size() == 0) chk(0, "R3", "unexpected beat", got, 0);
        else begin
          exp = exp_q.pop_front();
          chk(got == exp, "R3/R4/R5", "beat mismatch", got, exp);
        end
        if (tx_err) err_seen++;
        if (tx_eop) gap_pend = pkt_err || tx_err;
        pkt_err = tx_eop ? 0 : (pkt_err || tx_err);
        open = !tx_eop;
      end
    end
  end

  task automatic push_beat(bit sop, bit eop, bit emp, bit nable, bit nreq);
    bit mid, ok, nab;
    @(negedge clk);
    seq++;
    in_valid = 1; in_sop = sop; in_eop = eop; in_emp = emp;
    in_nable = nable; in_nreq = nreq; in_data = {4{seq}};
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    mid = !sop && !eop;
    nab = sop ? nable : m_nable;
    if (sop) begin m_nable = nable; m_done = 0; end
    ok = nreq && mid && nab && !m_done;
    if (ok) begin m_done = 1; exp_err++; end
    if (nreq && !ok) exp_rej++;
    exp_q.push_back({{4{seq}}, sop, eop, eop & emp, ok});
  endtask

  task automatic send_pkt(int len, bit nable, int nb1, int nb2, bit emp);
    for (int i = 0; i < len; i++)
      push_beat(i == 0, i == len - 1, emp, nable, (i == nb1) || (i == nb2));
    @(negedge clk);
    in_valid = 0; in_nreq = 0;
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 3000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "beats not delivered", exp_q.size(), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!tx_valid && !tx_err && !null_rej, "R8", "reset outputs", {tx_valid, tx_err, null_rej}, 0);
    chk(in_ready, "R8", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_basic();
    rdy_mode = 0;
    send_pkt(1, 0, -1, -1, 1);
    send_pkt(2, 0, -1, -1, 0);
    send_pkt(5, 1, -1, -1, 1);
    send_pkt(3, 0, -1, -1, 0);
    drain();
  endtask

  task automatic t_random();
    rdy_mode = 1;
    for (int p = 0; p < 30; p++)
      send_pkt(1 + int'($urandom % 12), bit'($urandom % 2),
               int'($urandom % 8) - 2, -1, bit'($urandom % 2));
    drain();
    rdy_mode = 3;
    for (int p = 0; p < 6; p++) send_pkt(2 + p, 1, 1, -1, bit'(p % 2));
    drain();
  endtask

  task automatic t_nullify();
    int e0 = err_seen;
    rdy_mode = 0;
    send_pkt(6, 1, 2, -1, 0);
    send_pkt(3, 0, -1, -1, 1);
    send_pkt(4, 1, 1, -1, 0);
    send_pkt(1, 0, -1, -1, 0);
    drain();
    chk(err_seen - e0 == 2, "R5", "nullify pulses", err_seen - e0, 2);
  endtask

  task automatic t_reject();
    int r0 = rej_seen, e0 = err_seen;
    rdy_mode = 0;
    send_pkt(4, 1, 0, 3, 0);
    send_pkt(4, 0, 1, -1, 0);
    send_pkt(5, 1, 1, 2, 1);
    send_pkt(2, 1, 1, -1, 0);
    drain();
    chk(rej_seen - r0 == 5, "R6", "reject pulses", rej_seen - r0, 5);
    chk(err_seen - e0 == 1, "R6", "only one honoured request", err_seen - e0, 1);
  endtask

  task automatic t_full();
    rdy_mode = 2;
    repeat (4) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) push_beat(i == 0, i == DEPTH - 1, 0, 0, 0);
    @(negedge clk);
    in_valid = 0;
    chk(!in_ready, "R8", "in_ready with buffer full", in_ready, 0);
    chk(!tx_valid, "R1", "valid while ready held low", tx_valid, 0);
    rdy_mode = 0;
    drain();
    chk(in_ready, "R8", "in_ready after drain", in_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_nullify();
    t_reject();
    t_random();
    t_full();
    chk(err_seen == exp_err, "R5", "total nullify pulses", err_seen, exp_err);
    chk(rej_seen == exp_rej, "R6", "total reject pulses", rej_seen, exp_rej);
    summary();
  end
endmodule